// File: doc/BRIEF.md
# Semi-decoupled four-phase latch controller

This block drives the enables of the two level-sensitive latches that take the place of one edge-triggered register when a synchronous pipeline is turned into a self-timed one. The first latch is the master and the second is the slave. An enable of 1 makes a latch transparent and 0 makes it opaque. The controller exchanges four-phase request/acknowledge pairs with the stage before it (`up_req`/`up_ack`) and with the stage after it (`dn_req`/`dn_ack`). Internally the master cell and the slave cell use a private pair of the same kind.

The design is a sampled model. Every handshake output and every enable moves at most once per clock, and only after the events that enable it have been seen on an earlier edge. The cells follow a semi-decoupled ordering:
- Rising half: request in, then the latch goes opaque, then request out.
- Falling half: request withdrawn, then the latch opens, then acknowledge released.

The return-to-zero phases of adjacent stages may overlap, so a stage can accept new input while its own output handshake is still pending. At reset, the master and the slave take opposite enable states. This leaves one data token in each pair, which is what a register holding its reset value has.

The handshakes are four-phase level pairs rather than valid/ready. The rules for back-pressure are as follows:
- A downstream stage that holds `dn_ack` high keeps the next `dn_req` low, and the slave keeps its item.
- A master holding an item acknowledged on `up_ack` stays opaque until `up_req` is withdrawn.

Top module: `desync_latch_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `up_ack` and `dn_req` go to 0. With `MASTER_HOLDS_TOKEN` = 1 (default), `mst_en` = 0 (opaque, holding the token) and `slv_en` = 1. With 0, the two enables are swapped.
- R2: The master goes opaque only on an edge where `up_req` is 1 and `up_ack` is 0. `up_ack` rises on the edge after the master went opaque.
- R3: The slave goes opaque only after the master has raised the internal request and is opaque. `dn_req` rises only while the slave is opaque. From reset with the default token, with no acknowledge pending, `slv_en` falls on the 2nd edge after reset release and `dn_req` rises on the 3rd edge.
- R4: No latch reopens before its successor has captured its item. The slave stays opaque until the downstream handshake for its item has completed with `dn_ack`. The master reopens only after the internal request has returned to 0.
- R5: A master whose item has been acknowledged on `up_ack` stays opaque while `up_req` is 1. After `up_req` falls, the master opens and `up_ack` falls on the following edge.
- R6: `dn_req` falls only after `dn_ack` is 1 and rises only while `dn_ack` is 0. While `dn_ack` is held at 1, no new `dn_req` is raised and the slave keeps its new item opaque.
- R7: The return-to-zero phases overlap. The master accepts and acknowledges a new upstream item while `dn_req` is still raised and not yet acknowledged.
- R8: `up_ack` rises only when `up_req` was 1 at that edge and falls only when it was 0. `dn_req` rises only when `dn_ack` was 0 and falls only when it was 1.
- R9: In a ring of three controllers, each master starts by holding a token. The sequence of values captured by each master latch and each slave latch matches the sequence held by a ring of three flip-flops with the same stage function and reset values, and the ring keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Request from the stage before |
| up_ack | output | 1 | Acknowledge to the stage before |
| dn_req | output | 1 | Request to the stage after |
| dn_ack | input | 1 | Acknowledge from the stage after |
| mst_en | output | 1 | Master latch enable, 1 = transparent |
| slv_en | output | 1 | Slave latch enable, 1 = transparent |

## Verification
A stale or wrong completion bit inside a cell shows up in one of two ways. It can reopen a latch while its successor has not yet captured the item. It can also raise a request twice for one item. The next sampled edge then shows this on `mst_en`, `slv_en` or `dn_req`, ahead of the handshake input that should have allowed it. A lost pending-acknowledge bit instead leaves `up_ack` low after the master closes, and the pipeline stalls within a few clocks. Value corruption in a closed ring shows as a mismatch against the flip-flop reference on the first lap after the fault.

// File: rtl/desync_pkg.sv
package desync_pkg;

  // State of one latch cell in the sampled model.
  typedef struct packed {
    logic open;     // latch enable, 1 = transparent
    logic pend;     // item captured, input acknowledge not yet raised
    logic passed;   // successor has captured the item currently held
    logic in_ack;   // acknowledge toward the predecessor
    logic out_req;  // request toward the successor
  } lcell_t;

  function automatic lcell_t lcell_reset(input logic holds_item);
    lcell_t s;
    s = '0;
    s.open = ~holds_item;
    return s;
  endfunction

endpackage

// File: rtl/latch_hs_cell.sv
module latch_hs_cell
  import desync_pkg::*;
#(
  parameter logic HOLDS_ITEM = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic in_req,
  output logic in_ack,
  output logic out_req,
  input  logic out_ack,
  output logic lat_en
);

  lcell_t cur;
  lcell_t nxt;
  logic   do_close;
  logic   do_open;

  // Close: a new request arrived and the previous acknowledge has been released.
  // Open: the successor has captured, and the input handshake is idle or returning.
  always_comb begin
    do_close = cur.open && in_req && !cur.in_ack;
    do_open  = !cur.open && cur.passed && (!cur.in_ack || !in_req);
  end

  always_comb begin
    nxt = cur;
    if (do_close) begin
      nxt.open   = 1'b0;
      nxt.passed = 1'b0;
      nxt.pend   = 1'b1;
    end else if (do_open) begin
      nxt.open = 1'b1;
    end

    if (cur.pend) begin
      nxt.in_ack = 1'b1;
      nxt.pend   = 1'b0;
    end else if (cur.in_ack && cur.open && !in_req) begin
      nxt.in_ack = 1'b0;
    end

    if (!cur.open && !cur.passed && !cur.out_req && !out_ack) begin
      nxt.out_req = 1'b1;
    end else if (cur.out_req && out_ack) begin
      nxt.out_req = 1'b0;
      nxt.passed  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= lcell_reset(HOLDS_ITEM);
    else     cur <= nxt;
  end

  assign in_ack  = cur.in_ack;
  assign out_req = cur.out_req;
  assign lat_en  = cur.open;

endmodule

// File: rtl/desync_latch_ctrl.sv
module desync_latch_ctrl #(
  parameter logic MASTER_HOLDS_TOKEN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic up_req,
  output logic up_ack,
  output logic dn_req,
  input  logic dn_ack,
  output logic mst_en,
  output logic slv_en
);

  localparam int NLAT = 2;

  logic [NLAT:0]   req_w;
  logic [NLAT:0]   ack_w;
  logic [NLAT-1:0] en_w;

  assign req_w[0]    = up_req;
  assign up_ack      = ack_w[0];
  assign dn_req      = req_w[NLAT];
  assign ack_w[NLAT] = dn_ack;

  for (genvar gi = 0; gi < NLAT; gi++) begin : g_lat
    localparam logic ITEM = MASTER_HOLDS_TOKEN ^ (gi % 2 == 1);
    latch_hs_cell #(.HOLDS_ITEM(ITEM)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .in_req  (req_w[gi]),
      .in_ack  (ack_w[gi]),
      .out_req (req_w[gi+1]),
      .out_ack (ack_w[gi+1]),
      .lat_en  (en_w[gi])
    );
  end

  assign mst_en = en_w[0];
  assign slv_en = en_w[NLAT-1];

endmodule

// File: rtl/desync_latch_ctrl_chk.sv
module desync_latch_ctrl_chk #(
  parameter logic MASTER_HOLDS_TOKEN = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic up_req,
  input logic up_ack,
  input logic dn_req,
  input logic dn_ack,
  input logic mst_en,
  input logic slv_en,
  input logic x_req,
  input logic x_ack
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!up_ack && !dn_req && !x_req && !x_ack &&
                    mst_en == !MASTER_HOLDS_TOKEN && slv_en == MASTER_HOLDS_TOKEN)); // R1

  AST_MST_CLOSE_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(mst_en) |-> ($past(up_req) && !$past(up_ack))); // R2

  AST_UPACK_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
    $rose(up_ack) |-> (!mst_en && !$past(mst_en))); // R2

  AST_SLV_CLOSE_ON_XREQ: assert property (@(posedge clk) disable iff (rst)
    $fell(slv_en) |-> ($past(x_req) && !mst_en)); // R3

  AST_DNREQ_SLAVE_OPAQUE: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) |-> !slv_en); // R3

  AST_SLV_OPEN_AFTER_DN: assert property (@(posedge clk) disable iff (rst)
    $rose(slv_en) |-> !$past(dn_req)); // R4

  AST_MST_OPEN_AFTER_X: assert property (@(posedge clk) disable iff (rst)
    $rose(mst_en) |-> !$past(x_req)); // R4

  AST_UPACK_FALL_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(up_ack) |-> (!$past(up_req) && $past(mst_en))); // R5

  AST_DNREQ_FALL_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(dn_req) |-> $past(dn_ack)); // R6

  AST_DNREQ_RISE_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) |-> !$past(dn_ack)); // R6

  AST_UPACK_RISE_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(up_ack) |-> $past(up_req)); // R8

  AST_XACK_PAIRED: assert property (@(posedge clk) disable iff (rst)
    $rose(x_ack) |-> $past(x_req)); // R8

endmodule

bind desync_latch_ctrl desync_latch_ctrl_chk #(.MASTER_HOLDS_TOKEN(MASTER_HOLDS_TOKEN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .up_req (up_req),
  .up_ack (up_ack),
  .dn_req (dn_req),
  .dn_ack (dn_ack),
  .mst_en (mst_en),
  .slv_en (slv_en),
  .x_req  (req_w[1]),
  .x_ack  (ack_w[1])
);

// File: tb/tb_desync_latch_ctrl.sv
`timescale 1ns/1ps
module tb_desync_latch_ctrl;

  localparam int CLK_HALF = 4;
  localparam int NST      = 3;
  localparam int NCAP     = 6;
  localparam int CAPMAX   = 8;

  logic clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  logic rst, up_req, dn_ack;
  logic up_ack, dn_req, mst_en, slv_en;
  int n_tests = 0;
  int n_fail  = 0;
  int mon_err = 0;

  desync_latch_ctrl dut (
    .clk(clk), .rst(rst), .up_req(up_req), .up_ack(up_ack),
    .dn_req(dn_req), .dn_ack(dn_ack), .mst_en(mst_en), .slv_en(slv_en)
  );

  // ---------------- ring of three controllers ----------------
  logic           rst_ring;
  logic [NST-1:0] r_req, r_ack_up, r_ack_d, r_men, r_sen;
  logic [15:0]    lfsr;
  logic [1:0]     dly [NST];
  logic [7:0]     m_dat [NST];
  logic [7:0]     s_dat [NST];

  for (genvar g = 0; g < NST; g++) begin : g_ring
    desync_latch_ctrl ring_u (
      .clk(clk), .rst(rst_ring), .up_req(r_req[(g+NST-1)%NST]), .up_ack(r_ack_up[g]),
      .dn_req(r_req[g]), .dn_ack(r_ack_d[g]), .mst_en(r_men[g]), .slv_en(r_sen[g])
    );
  end

  function automatic logic [7:0] stage_f(input logic [7:0] x);
    return 8'(x * 3 + 1);
  endfunction

  function automatic logic [7:0] seed(input int i);
    return 8'(17 * i + 5);
  endfunction

  always @(posedge clk) begin
    lfsr <= rst_ring ? 16'hACE1 : {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int i = 0; i < NST; i++) begin
      // acknowledge link with a random delay of 0..3 clocks
      if (rst_ring) begin
        r_ack_d[i] <= 1'b0;
        dly[i]     <= 2'd0;
      end else if (r_ack_d[i] != r_ack_up[(i+1)%NST]) begin
        if (dly[i] == 2'd0) begin
          r_ack_d[i] <= r_ack_up[(i+1)%NST];
          dly[i]     <= lfsr[2*i +: 2];
        end else begin
          dly[i] <= dly[i] - 2'd1;
        end
      end
      // latch data model: a transparent latch follows its input
      if (rst_ring)      m_dat[i] <= seed(i);
      else if (r_men[i]) m_dat[i] <= stage_f(s_dat[(i+NST-1)%NST]);
      if (r_sen[i])      s_dat[i] <= m_dat[i];
    end
  end

  logic [7:0] s_cap [NST][CAPMAX];
  logic [7:0] m_cap [NST][CAPMAX];
  int s_cnt [NST];
  int m_cnt [NST];
  logic [NST-1:0] prev_men, prev_sen;

  always @(negedge clk) begin
    #2;
    for (int i = 0; i < NST; i++) begin
      if (rst_ring) begin
        s_cnt[i] = 0;
        m_cnt[i] = 0;
      end else begin
        if (prev_sen[i] && !r_sen[i] && s_cnt[i] < CAPMAX) begin
          s_cap[i][s_cnt[i]] = s_dat[i];
          s_cnt[i]++;
        end
        if (prev_men[i] && !r_men[i] && m_cnt[i] < CAPMAX) begin
          m_cap[i][m_cnt[i]] = m_dat[i];
          m_cnt[i]++;
        end
      end
    end
    prev_men = r_men;
    prev_sen = r_sen;
  end

  // ---------------- handshake monitor on dut (R8) ----------------
  logic p_upack, p_dnreq, nx_upreq, nx_dnack, p_rst;
  initial p_rst = 1'b1;
  always @(negedge clk) begin
    #2;
    if (!rst && !p_rst) begin
      if (up_ack && !p_upack && !nx_upreq) mon_err++;
      if (!up_ack && p_upack && nx_upreq)  mon_err++;
      if (dn_req && !p_dnreq && nx_dnack)  mon_err++;
      if (!dn_req && p_dnreq && !nx_dnack) mon_err++;
    end
    p_rst    = rst;
    p_upack  = up_ack;
    p_dnreq  = dn_req;
    nx_upreq = up_req;
    nx_dnack = dn_ack;
  end

  // ---------------- helpers ----------------
  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0:       return up_ack;
      1:       return dn_req;
      2:       return mst_en;
      default: return slv_en;
    endcase
  endfunction

  task automatic wait_for(input int which, input logic val, input int limit, output int cyc);
    cyc = -1;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (pick(which) == val) begin
        cyc = n;
        break;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; up_req = 1'b0; dn_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1; up_req = 1'b0; dn_ack = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R1", "up_ack in reset", int'(up_ack), 0);
    check_eq("R1", "dn_req in reset", int'(dn_req), 0);
    check_eq("R1", "mst_en in reset", int'(mst_en), 0);
    check_eq("R1", "slv_en in reset", int'(slv_en), 1);
  endtask

  task automatic t_launch_and_hold();
    int c;
    do_reset();
    up_req = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R3", "slv_en after edge 2", int'(slv_en), 0);
    check_eq("R3", "dn_req after edge 2", int'(dn_req), 0);
    @(negedge clk);
    check_eq("R3", "dn_req after edge 3", int'(dn_req), 1);
    wait_for(0, 1'b1, 10, c);
    check_eq("R7", "up_ack rises while dn_req pending", int'(c > 0), 1);
    check_eq("R7", "dn_req still raised at upstream ack", int'(dn_req), 1);
    repeat (15) @(negedge clk);
    check_eq("R4", "slave opaque without dn_ack", int'(slv_en), 0);
    check_eq("R4", "master opaque with slave full", int'(mst_en), 0);
    dn_ack = 1'b1;
    wait_for(1, 1'b0, 5, c);
    check_eq("R6", "dn_req withdrawn after dn_ack", int'(c > 0), 1);
    dn_ack = 1'b0;
    wait_for(3, 1'b1, 5, c);
    check_eq("R4", "slave reopens after handshake", int'(c > 0), 1);
    up_req = 1'b0;
  endtask

  task automatic t_upstream();
    int c;
    logic prev_m, saw_open, got;
    do_reset();
    up_req = 1'b1;
    prev_m = mst_en; saw_open = 1'b0; got = 1'b0;
    for (int n = 0; n < 20 && !got; n++) begin
      @(negedge clk);
      if (mst_en) saw_open = 1'b1;
      if (up_ack) begin
        got = 1'b1;
        check_eq("R2", "master opaque at up_ack rise", int'(mst_en), 0);
        check_eq("R2", "master opaque one clock before up_ack", int'(prev_m), 0);
      end
      prev_m = mst_en;
    end
    check_eq("R2", "master reopened then captured", int'(saw_open && got), 1);
    dn_ack = 1'b1;
    wait_for(1, 1'b0, 5, c);
    dn_ack = 1'b0;
    repeat (12) @(negedge clk);
    check_eq("R5", "master opaque while up_req held", int'(mst_en), 0);
    check_eq("R5", "up_ack held while up_req held", int'(up_ack), 1);
    up_req = 1'b0;
    wait_for(2, 1'b1, 5, c);
    check_eq("R5", "master opens after up_req falls", int'(c > 0), 1);
    check_eq("R5", "up_ack still high when master opens", int'(up_ack), 1);
    @(negedge clk);
    check_eq("R5", "up_ack falls one clock later", int'(up_ack), 0);
    dn_ack = 1'b1;
    wait_for(1, 1'b0, 5, c);
    dn_ack = 1'b0;
  endtask

  task automatic t_dn_backpressure();
    int c;
    do_reset();
    wait_for(1, 1'b1, 10, c);
    dn_ack = 1'b1;
    wait_for(1, 1'b0, 5, c);
    up_req = 1'b1;
    wait_for(0, 1'b1, 15, c);
    up_req = 1'b0;
    wait_for(0, 1'b0, 10, c);
    repeat (10) @(negedge clk);
    check_eq("R6", "no new dn_req while dn_ack high", int'(dn_req), 0);
    check_eq("R6", "slave keeps new item opaque", int'(slv_en), 0);
    dn_ack = 1'b0;
    wait_for(1, 1'b1, 3, c);
    check_eq("R6", "dn_req rises after dn_ack low", int'(c > 0), 1);
    dn_ack = 1'b1;
    wait_for(1, 1'b0, 5, c);
    dn_ack = 1'b0;
  endtask

  task automatic t_ring();
    logic [7:0] ref_v [CAPMAX+1][NST];
    logic done;
    for (int i = 0; i < NST; i++) ref_v[0][i] = seed(i);
    for (int k = 0; k < CAPMAX; k++)
      for (int i = 0; i < NST; i++) ref_v[k+1][i] = stage_f(ref_v[k][(i+NST-1)%NST]);
    rst_ring = 1'b1;
    repeat (3) @(negedge clk);
    rst_ring = 1'b0;
    done = 1'b0;
    for (int n = 0; n < 3000 && !done; n++) begin
      @(negedge clk);
      #3;
      done = 1'b1;
      for (int i = 0; i < NST; i++)
        if (s_cnt[i] < NCAP || m_cnt[i] < NCAP) done = 1'b0;
    end
    check_eq("R9", "ring live to capture count", int'(done), 1);
    for (int i = 0; i < NST; i++)
      for (int k = 0; k < NCAP; k++) begin
        check_eq("R9", $sformatf("slave %0d capture %0d", i, k), int'(s_cap[i][k]), int'(ref_v[k][i]));
        check_eq("R9", $sformatf("master %0d capture %0d", i, k), int'(m_cap[i][k]), int'(ref_v[k+1][i]));
      end
  endtask

  initial begin
    rst = 1'b1; rst_ring = 1'b1; up_req = 1'b0; dn_ack = 1'b0;
    t_reset();
    t_launch_and_hold();
    t_upstream();
    t_dn_backpressure();
    t_ring();
    check_eq("R8", "handshake monitor violations", mon_err, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_HALF * 2 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule